// File: doc/BRIEF.md
# Two-Lane Double-Edge Sample Word Deserializer

This block sits behind one channel of a multi-channel data converter whose output is serial. Each sample arrives as a 16-bit word split across two lanes. Both lanes change on every edge of a forwarded bit clock. A separate frame signal, running at the sample rate, rises at the start of each word. The block captures the lanes on both clock edges, finds word starts from the frame signal, and puts the bits back into a word. It can also flip between the twos-complement and offset-binary codings, and it outputs the word and the 14-bit conversion result with a one-cycle valid strobe.

The whole block runs on the bit clock. The falling-edge half is staged in a register, and both halves of each clock period are consumed at the following rising edge. Outputs are registered and keep their value between strobes.

Top module: `dlane_deser`

## Requirements
- R1: While `rst_i` is high at a rising edge, the next values of `valid_o`, `word_o` and `data_o` are all zero.
- R2: Within a word, the first half-period carries bit 15 on `lane_i[1]` and bit 14 on `lane_i[0]`, and each following half-period carries the next lower pair. Lane 1 holds the odd positions and lane 0 holds the even positions.
- R3: Lane bits are taken on both the falling and the rising edge. A word may begin on either edge.
- R4: A half-period whose frame sample is 1, after a half-period whose frame sample was 0, is the first of 8 half-periods that form one word. With words sent back to back, each word is recovered.
- R5: `valid_o` is high for exactly one clock per completed word and is never high in two consecutive cycles.
- R6: No strobe occurs unless a frame boundary came first. After reset, a frame held high shows no boundary until it has been seen low. Half-periods that arrive after a completed word, before the next boundary, produce no strobe.
- R7: A boundary that arrives before the current word is complete restarts assembly. The partial word is dropped and never presented.
- R8: With `fmt_i` = 0 the word is output as received. With `fmt_i` = 1, bit 15 is inverted: 0x7FFC becomes 0xFFFC, 0x0000 becomes 0x8000 and 0x8000 becomes 0x0000. `fmt_i` is sampled at the edge where the word completes.
- R9: `data_o` equals bits 15 down to 2 of `word_o`, which is the left-justified 14-bit result.
- R10: `word_o` and `data_o` hold their values in every cycle in which `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Forwarded bit clock; lanes and frame are sampled on both edges |
| rst_i | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Frame signal, rises at each word start |
| lane_i | input | LANES (2) | Serial lane bits; bit 1 holds odd positions, bit 0 holds even positions |
| fmt_i | input | 1 | 1 inverts the word MSB (coding conversion), 0 passes the word through |
| valid_o | output | 1 | One-cycle strobe for each completed word |
| word_o | output | WORD_W (16) | Recovered word after coding conversion |
| data_o | output | RES_W (14) | Left-justified conversion result taken from the word |

## Verification
Directed words with only the top pair set, or only the bottom pair set, separate a lane swap from a reversed bit order. Frame-low gaps of odd length move word starts between the falling and rising edges, so an error that affects only one edge shows up as corrupted words. The full-scale and zero codes are sent under both coding settings, and a word cut short by an early boundary checks that partial data is dropped. Runs of random words, with random-length gaps and alternating coding, exercise back-to-back framing and show that gaps raise no strobe.

// File: rtl/dlane_pkg.sv
package dlane_pkg;

    // assembler progress: waiting for a frame boundary or filling a word
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_FILL = 1'b1
    } asm_state_e;

    // output coding selection
    typedef enum logic {
        FMT_PASS = 1'b0,
        FMT_FLIP = 1'b1
    } fmt_e;

endpackage

// File: rtl/dlane_half_capture.sv
module dlane_half_capture #(
    parameter int LANES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             frame_i,
    input  logic [LANES-1:0] lane_i,
    output logic             fall_frame_o,
    output logic [LANES-1:0] fall_lane_o
);

    typedef struct packed {
        logic             frame;
        logic [LANES-1:0] bits;
    } half_t;

    half_t half_d, half_q;

    // reset frame to 1 so a frame held high through reset shows no edge
    always_comb begin
        half_d.frame = rst_i ? 1'b1 : frame_i;
        half_d.bits  = rst_i ? '0   : lane_i;
    end

    always_ff @(negedge clk_i) begin
        half_q <= half_d;
    end

    assign fall_frame_o = half_q.frame;
    assign fall_lane_o  = half_q.bits;

endmodule

// File: rtl/dlane_word_assembler.sv
module dlane_word_assembler
    import dlane_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              fall_frame_i,
    input  logic [LANES-1:0]  fall_lane_i,
    input  logic              rise_frame_i,
    input  logic [LANES-1:0]  rise_lane_i,
    output logic              done_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int HALVES = WORD_W / LANES;
    localparam int CNT_W  = (HALVES > 1) ? $clog2(HALVES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALVES - 1);

    typedef struct packed {
        asm_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic              prev_fr;
    } asm_t;

    asm_t asm_d, asm_q;
    logic              done_d;
    logic [WORD_W-1:0] word_d;

    // slot 0 is the earlier (falling-edge) half, slot 1 the rising-edge half
    logic [1:0]            slot_fr;
    logic [1:0][LANES-1:0] slot_bits;

    assign slot_fr[0]   = fall_frame_i;
    assign slot_fr[1]   = rise_frame_i;
    assign slot_bits[0] = fall_lane_i;
    assign slot_bits[1] = rise_lane_i;

    always_comb begin
        asm_d  = asm_q;
        done_d = 1'b0;
        word_d = '0;
        for (int s = 0; s < 2; s++) begin
            if (slot_fr[s] && !asm_d.prev_fr) begin
                asm_d.st  = ST_FILL;
                asm_d.cnt = '0;
            end
            asm_d.prev_fr = slot_fr[s];
            if (asm_d.st == ST_FILL) begin
                asm_d.sh = {asm_d.sh[WORD_W-LANES-1:0], slot_bits[s]};
                if (asm_d.cnt == LAST) begin
                    done_d    = 1'b1;
                    word_d    = asm_d.sh;
                    asm_d.st  = ST_WAIT;
                    asm_d.cnt = '0;
                end else begin
                    asm_d.cnt = asm_d.cnt + CNT_W'(1);
                end
            end
        end
        if (rst_i) begin
            asm_d.st      = ST_WAIT;
            asm_d.cnt     = '0;
            asm_d.sh      = '0;
            asm_d.prev_fr = 1'b1;
            done_d        = 1'b0;
            word_d        = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        asm_q <= asm_d;
    end

    // completion is handed on combinationally; the formatter registers it
    assign done_o = done_d;
    assign word_o = word_d;

endmodule

// File: rtl/dlane_formatter.sv
module dlane_formatter
    import dlane_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int RES_W  = 14
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              done_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              fmt_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o,
    output logic [RES_W-1:0]  data_o
);

    localparam logic [WORD_W-1:0] MSB_MASK = {1'b1, {(WORD_W-1){1'b0}}};

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        logic [RES_W-1:0]  data;
    } out_t;

    out_t out_d, out_q;
    logic [WORD_W-1:0] coded;

    always_comb begin
        coded = (fmt_e'(fmt_i) == FMT_FLIP) ? (word_i ^ MSB_MASK) : word_i;
        out_d = out_q;
        out_d.valid = done_i;
        if (done_i) begin
            out_d.word = coded;
            out_d.data = coded[WORD_W-1 -: RES_W];
        end
        if (rst_i) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        out_q <= out_d;
    end

    assign valid_o = out_q.valid;
    assign word_o  = out_q.word;
    assign data_o  = out_q.data;

endmodule

// File: rtl/dlane_deser.sv
module dlane_deser #(
    parameter int WORD_W = 16,
    parameter int RES_W  = 14,
    parameter int LANES  = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              frame_i,
    input  logic [LANES-1:0]  lane_i,
    input  logic              fmt_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o,
    output logic [RES_W-1:0]  data_o
);

    logic              fall_frame;
    logic [LANES-1:0]  fall_lane;
    logic              asm_done;
    logic [WORD_W-1:0] asm_word;

    dlane_half_capture #(.LANES(LANES)) u_cap (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .frame_i      (frame_i),
        .lane_i       (lane_i),
        .fall_frame_o (fall_frame),
        .fall_lane_o  (fall_lane)
    );

    dlane_word_assembler #(.WORD_W(WORD_W), .LANES(LANES)) u_asm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .fall_frame_i (fall_frame),
        .fall_lane_i  (fall_lane),
        .rise_frame_i (frame_i),
        .rise_lane_i  (lane_i),
        .done_o       (asm_done),
        .word_o       (asm_word)
    );

    dlane_formatter #(.WORD_W(WORD_W), .RES_W(RES_W)) u_fmt (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .done_i  (asm_done),
        .word_i  (asm_word),
        .fmt_i   (fmt_i),
        .valid_o (valid_o),
        .word_o  (word_o),
        .data_o  (data_o)
    );

endmodule

// File: rtl/dlane_deser_chk.sv
module dlane_deser_chk #(
    parameter int WORD_W = 16,
    parameter int RES_W  = 14
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              frame_i,
    input logic              valid_o,
    input logic [WORD_W-1:0] word_o,
    input logic [RES_W-1:0]  data_o
);

    // independent boundary tracker built from the frame port alone
    logic fr_neg_q;
    logic fr_pos_q;
    logic armed_q;
    logic edge_seen;

    always_ff @(negedge clk_i) begin
        fr_neg_q <= rst_i ? 1'b1 : frame_i;
    end

    assign edge_seen = (!fr_pos_q && fr_neg_q) || (!fr_neg_q && frame_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fr_pos_q <= 1'b1;
            armed_q  <= 1'b0;
        end else begin
            fr_pos_q <= frame_i;
            armed_q  <= armed_q | edge_seen;
        end
    end

    // R5
    single_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

    // R6
    strobe_after_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> armed_q);

    // R10
    word_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> $stable(word_o));

    // R10
    data_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> $stable(data_o));

    // R9
    result_slice_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        data_o == word_o[WORD_W-1 -: RES_W]);

endmodule

bind dlane_deser dlane_deser_chk #(.WORD_W(WORD_W), .RES_W(RES_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .frame_i (frame_i),
    .valid_o (valid_o),
    .word_o  (word_o),
    .data_o  (data_o)
);

// File: tb/dlane_deser_test.sv
module dlane_deser_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_i;
    logic [1:0]  lane_i;
    logic        fmt_i;
    logic        valid_o;
    logic [15:0] word_o;
    logic [13:0] data_o;

    int checks = 0;
    int fails  = 0;
    int hidx   = 0;
    int vcount = 0;
    int pushed = 0;
    logic        prev_valid = 1'b0;
    logic [15:0] held = 16'h0000;
    logic        started = 1'b0;

    logic [15:0] exp_w[$];
    string       exp_tag[$];

    always #5 clk = ~clk;

    dlane_deser uut (
        .clk_i   (clk),
        .rst_i   (rst),
        .frame_i (frame_i),
        .lane_i  (lane_i),
        .fmt_i   (fmt_i),
        .valid_o (valid_o),
        .word_o  (word_o),
        .data_o  (data_o)
    );

    function automatic logic [15:0] coded(input logic [15:0] w, input logic f);
        return f ? (w ^ 16'h8000) : w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // one half-period: even halves are taken at a falling edge, odd at a rising edge
    task automatic put_half(input logic fr, input logic [1:0] b);
        if (hidx[0] == 1'b0) @(posedge clk);
        else @(negedge clk);
        #2;
        frame_i = fr;
        lane_i  = b;
        hidx++;
    endtask

    task automatic send_word(input logic [15:0] w, input string tag);
        exp_w.push_back(coded(w, fmt_i));
        exp_tag.push_back(tag);
        pushed++;
        for (int h = 0; h < 8; h++) begin
            put_half(h < 4, w[15-2*h -: 2]);
        end
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            put_half(1'b0, 2'($urandom));
        end
    endtask

    // output monitor, sampling at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (started && !rst) begin
                if (valid_o) begin
                    vcount++;
                    check(!prev_valid, "R5 strobe width", 16'(prev_valid), 16'h0);
                    if (exp_w.size() == 0) begin
                        check(1'b0, "R6 unexpected strobe", word_o, 16'h0);
                    end else begin
                        logic [15:0] e;
                        string t;
                        e = exp_w.pop_front();
                        t = exp_tag.pop_front();
                        check(word_o == e, t, word_o, e);
                        check(data_o == e[15:2], "R9 result", 16'(data_o), 16'(e[15:2]));
                    end
                    held = word_o;
                end else begin
                    check(word_o == held, "R10 hold", word_o, held);
                end
                prev_valid = valid_o;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst = 1'b1; frame_i = 1'b1; lane_i = 2'b11; fmt_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(valid_o == 1'b0, "R1 valid", 16'(valid_o), 16'h0);
        check(word_o == 16'h0, "R1 word", word_o, 16'h0);
        check(data_o == 14'h0, "R1 data", 16'(data_o), 16'h0);
        @(posedge clk);
        #2 rst = 1'b0;
        started = 1'b1;

        // R6: frame high since reset, then low: no boundary, no strobe
        for (int i = 0; i < 10; i++) put_half(1'b1, 2'($urandom));
        gap(6);
        repeat (2) @(negedge clk);
        check(vcount == 0, "R6 no boundary yet", 16'(vcount), 16'h0);

        // R2: lane and order mapping
        send_word(16'hC000, "R2 top pair");
        send_word(16'h0003, "R2 bottom pair");
        send_word(16'h4001, "R2 lane split");
        // R3: odd gap moves the start to the other edge
        gap(3);
        send_word(16'hA5A4, "R3 rising-edge start");
        send_word(16'h5A5B, "R3 back to back");
        gap(2);
        fmt_i = 1'b1;
        // R8: full-scale and zero codes with conversion
        send_word(16'h7FFC, "R8 positive full scale");
        send_word(16'h0000, "R8 zero");
        send_word(16'h8000, "R8 negative full scale");
        // R7: early boundary drops the partial word
        gap(2);
        put_half(1'b1, 2'b11); put_half(1'b1, 2'b11);
        put_half(1'b1, 2'b11); put_half(1'b1, 2'b11);
        put_half(1'b0, 2'b11);
        send_word(16'h1234, "R7 restart");
        // R6: a long gap after a word gives no strobe
        gap(12);
        repeat (2) @(negedge clk);
        check(vcount == pushed, "R6 gap silent", 16'(vcount), 16'(pushed));

        // R4: random back-to-back words, random gaps, alternating coding
        for (int seg = 0; seg < 4; seg++) begin
            gap(2);
            fmt_i = seg[0];
            gap(int'($urandom % 4));
            for (int k = 0; k < 20; k++) begin
                send_word(16'($urandom), "R4 random word");
            end
        end
        gap(8);
        repeat (4) @(negedge clk);
        check(vcount == pushed, "R5 strobe count", 16'(vcount), 16'(pushed));
        check(exp_w.size() == 0, "R5 missing words", 16'(exp_w.size()), 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule